// File: doc/BRIEF.md
# Translation Cache with Reference/Dirty Write-Through

This block is a small fully associative translation cache. It holds page table entries, and it keeps the memory copy of each entry's reference and dirty bits current. On a lookup it returns the physical page of a virtual page. On a miss it issues one refill request. It installs the returned entry, marks it referenced (and dirty for a write), and writes the updated entry back to memory only when one of those bits actually changed from zero.

A write that hits costs one memory write the first time it dirties the page. Every later hit on that page is silent. A read that hits never writes, because a resident entry is always referenced. A translation is reported only after its entry write has been accepted, so memory never lags the cached bits.

Software that edits an entry in memory (for example, clearing its reference or dirty bits) purges the cached copy. It can purge one virtual page or every entry. A purge that names the page of a refill still in flight makes the block drop that refill's data and request the entry again. A static mode input forces the entry write on every miss and skips the bit inspection.

Top module: `tlb_rd_wb`

## Requirements
- R1: After reset, no entry is valid, `lk_ready` is 1, and `rs_valid`, `rq_valid` and `wb_valid` are 0. The first lookup of any page is a miss.
- R2: On a read miss the block raises `rq_valid` with `rq_vpn` equal to the looked-up page. When the refill arrives, the entry's reference bit is set. An entry write is issued only if the fetched reference bit was 0. Entry layout: bit 0 is reference, bit 1 is dirty, and the bits above them are the physical page.
- R3: On a write miss both bits are set. An entry write is issued when either fetched bit was 0 (patterns 00, 01 and 10), and it carries both bits set.
- R4: A read hit returns the cached physical page on `rs_valid` one cycle after acceptance. It issues no refill and no entry write.
- R5: A write hit issues an entry write with both bits set only if the cached dirty bit is 0, and then sets that bit. Further write hits on the page issue no write.
- R6: `rs_valid` for a translation that needs an entry write is raised only after `wb_valid` has been accepted by `wb_ready`. `wb_valid`, `wb_addr` and `wb_data` hold steady until then.
- R7: A single purge invalidates only the entry whose page equals `pg_vpn`. Other entries still hit.
- R8: A purge with `pg_all` set invalidates every entry.
- R9: A purge of the page of an outstanding refill discards the refill data and issues a new refill request. This applies both while the request or the wait is pending and in the same cycle as `fr_valid`.
- R10: A purge of a page in the same cycle as a lookup of that page makes the lookup a miss.
- R11: With `mode_wt` at 1, every miss issues an entry write, even when both fetched bits were already 1. Hits are unaffected.
- R12: The block holds 8 entries and replaces them in round-robin order starting at slot 0. A refill reuses a valid entry of the same page instead of allocating.
- R13: `wb_addr` is the entry address delivered with the refill (`fr_addr`) that installed the entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wt | input | 1 | 1: write the entry back on every miss |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a store |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_ready | output | 1 | Block is idle and accepts a lookup |
| rs_valid | output | 1 | One-cycle translation result pulse |
| rs_ppn | output | PPN_W | Translated physical page |
| rq_valid | output | 1 | Refill request |
| rq_vpn | output | VPN_W | Page whose entry is requested |
| rq_ready | input | 1 | Refill request accepted |
| fr_valid | input | 1 | Refill data valid |
| fr_pte | input | PPN_W+2 | Fetched page table entry |
| fr_addr | input | PA_W | Memory address of the fetched entry |
| wb_valid | output | 1 | Entry write request |
| wb_ready | input | 1 | Entry write accepted |
| wb_addr | output | PA_W | Address of the entry to write |
| wb_data | output | PPN_W+2 | Updated entry |
| pg_valid | input | 1 | Purge request, always accepted |
| pg_all | input | 1 | Purge every entry |
| pg_vpn | input | VPN_W | Page to purge when `pg_all` is 0 |

## Verification
Two pairs of events can land in the same cycle. The first is a purge arriving together with the refill data for the same page. The bench raises `pg_valid` in the very cycle it drives `fr_valid`, and passes only if the block issues a second refill request and still returns the right page. The second is a purge arriving together with a lookup of a resident page. That case passes only if the block treats the lookup as a miss and requests a refill.

// File: rtl/tlbwb_pkg.sv
package tlbwb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2,
        ST_WB   = 2'd3
    } tlbwb_state_e;
endpackage

// File: rtl/tlbwb_cam.sv
module tlbwb_cam #(
    parameter int N  = 8,
    parameter int KW = 8
) (
    input  logic [N-1:0][KW-1:0] keys,
    input  logic [N-1:0]         live,
    input  logic [KW-1:0]        probe,
    output logic [N-1:0]         hits
);
    for (genvar g = 0; g < N; g++) begin : g_cmp
        assign hits[g] = live[g] && (keys[g] == probe);
    end
endmodule

// File: rtl/tlbwb_pick.sv
module tlbwb_pick #(
    parameter int N     = 8,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/tlbwb_bits.sv
module tlbwb_bits (
    input  logic old_ref,
    input  logic old_dirty,
    input  logic is_write,
    input  logic force_wt,
    output logic new_dirty,
    output logic need_wb
);
    // reference is always set on install; dirty follows the access kind
    assign new_dirty = old_dirty | is_write;
    assign need_wb   = force_wt | ~old_ref | (is_write & ~old_dirty);
endmodule

// File: rtl/tlb_rd_wb.sv
module tlb_rd_wb
    import tlbwb_pkg::*;
#(
    parameter int N     = 8,
    parameter int VPN_W = 8,
    parameter int PPN_W = 12,
    parameter int PA_W  = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_wt,
    input  logic             lk_valid,
    input  logic             lk_write,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_ready,
    output logic             rs_valid,
    output logic [PPN_W-1:0] rs_ppn,
    output logic             rq_valid,
    output logic [VPN_W-1:0] rq_vpn,
    input  logic             rq_ready,
    input  logic             fr_valid,
    input  logic [PPN_W+1:0] fr_pte,
    input  logic [PA_W-1:0]  fr_addr,
    output logic             wb_valid,
    input  logic             wb_ready,
    output logic [PA_W-1:0]  wb_addr,
    output logic [PPN_W+1:0] wb_data,
    input  logic             pg_valid,
    input  logic             pg_all,
    input  logic [VPN_W-1:0] pg_vpn
);
    localparam int IDX_W = $clog2(N);
    localparam int PTE_W = PPN_W + 2;

    typedef struct packed {
        tlbwb_state_e                st;
        logic [VPN_W-1:0]            vpn;
        logic                        wr;
        logic                        kill;
        logic                        set_d;
        logic [IDX_W-1:0]            idx;
        logic [IDX_W-1:0]            rr;
        logic [PA_W-1:0]             wb_addr;
        logic [PTE_W-1:0]            wb_data;
        logic                        rs_valid;
        logic [PPN_W-1:0]            rs_ppn;
        logic [N-1:0]                v;
        logic [N-1:0]                db;
        logic [N-1:0][VPN_W-1:0]     ev;
        logic [N-1:0][PPN_W-1:0]     ep;
        logic [N-1:0][PA_W-1:0]      ea;
    } tlbwb_regs_t;

    tlbwb_regs_t r_q, r_d;

    logic [N-1:0]     pg_hits, pmask, live, lk_hits, fl_hits;
    logic             lk_any, fl_any, pg_same;
    logic [IDX_W-1:0] lk_idx, fl_idx, slot;
    logic [PPN_W-1:0] fr_ppn;
    logic             nb_dirty, nb_need;

    assign pmask   = pg_valid ? (pg_all ? {N{1'b1}} : pg_hits) : '0;
    assign live    = r_q.v & ~pmask;
    assign pg_same = pg_valid && (pg_all || (pg_vpn == r_q.vpn));
    assign fr_ppn  = fr_pte[PTE_W-1:2];
    assign slot    = fl_any ? fl_idx : r_q.rr;

    tlbwb_cam #(.N(N), .KW(VPN_W)) u_cam_pg (
        .keys(r_q.ev), .live(r_q.v), .probe(pg_vpn), .hits(pg_hits));
    tlbwb_cam #(.N(N), .KW(VPN_W)) u_cam_lk (
        .keys(r_q.ev), .live(live), .probe(lk_vpn), .hits(lk_hits));
    tlbwb_cam #(.N(N), .KW(VPN_W)) u_cam_fl (
        .keys(r_q.ev), .live(live), .probe(r_q.vpn), .hits(fl_hits));

    tlbwb_pick #(.N(N), .IDX_W(IDX_W)) u_pick_lk (
        .vec(lk_hits), .any(lk_any), .idx(lk_idx));
    tlbwb_pick #(.N(N), .IDX_W(IDX_W)) u_pick_fl (
        .vec(fl_hits), .any(fl_any), .idx(fl_idx));

    tlbwb_bits u_bits (
        .old_ref(fr_pte[0]), .old_dirty(fr_pte[1]), .is_write(r_q.wr),
        .force_wt(mode_wt), .new_dirty(nb_dirty), .need_wb(nb_need));

    always_comb begin
        r_d          = r_q;
        r_d.rs_valid = 1'b0;
        r_d.v        = live;
        case (r_q.st)
            ST_IDLE: begin
                if (lk_valid) begin
                    r_d.vpn  = lk_vpn;
                    r_d.wr   = lk_write;
                    r_d.kill = 1'b0;
                    if (lk_any) begin
                        if (lk_write && !r_q.db[lk_idx]) begin
                            r_d.st      = ST_WB;
                            r_d.idx     = lk_idx;
                            r_d.set_d   = 1'b1;
                            r_d.wb_addr = r_q.ea[lk_idx];
                            r_d.wb_data = {r_q.ep[lk_idx], 2'b11};
                        end else begin
                            r_d.rs_valid = 1'b1;
                            r_d.rs_ppn   = r_q.ep[lk_idx];
                        end
                    end else begin
                        r_d.st = ST_REQ;
                    end
                end
            end
            ST_REQ: begin
                if (pg_same) r_d.kill = 1'b1;
                if (rq_ready) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (pg_same) r_d.kill = 1'b1;
                if (fr_valid) begin
                    if (r_q.kill || pg_same) begin
                        r_d.kill = 1'b0;
                        r_d.st   = ST_REQ;
                    end else begin
                        if (!fl_any) begin
                            r_d.rr = (r_q.rr == IDX_W'(N - 1)) ? '0 : r_q.rr + 1'b1;
                        end
                        r_d.v[slot]  = 1'b1;
                        r_d.ev[slot] = r_q.vpn;
                        r_d.ep[slot] = fr_ppn;
                        r_d.ea[slot] = fr_addr;
                        r_d.db[slot] = nb_dirty;
                        r_d.idx      = slot;
                        r_d.set_d    = 1'b0;
                        if (nb_need) begin
                            r_d.st      = ST_WB;
                            r_d.wb_addr = fr_addr;
                            r_d.wb_data = {fr_ppn, nb_dirty, 1'b1};
                        end else begin
                            r_d.st       = ST_IDLE;
                            r_d.rs_valid = 1'b1;
                            r_d.rs_ppn   = fr_ppn;
                        end
                    end
                end
            end
            ST_WB: begin
                if (wb_ready) begin
                    if (r_q.set_d) r_d.db[r_q.idx] = 1'b1;
                    r_d.st       = ST_IDLE;
                    r_d.rs_valid = 1'b1;
                    r_d.rs_ppn   = r_q.wb_data[PTE_W-1:2];
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign lk_ready = (r_q.st == ST_IDLE);
    assign rq_valid = (r_q.st == ST_REQ);
    assign rq_vpn   = r_q.vpn;
    assign wb_valid = (r_q.st == ST_WB);
    assign wb_addr  = r_q.wb_addr;
    assign wb_data  = r_q.wb_data;
    assign rs_valid = r_q.rs_valid;
    assign rs_ppn   = r_q.rs_ppn;
endmodule

// File: rtl/tlb_rd_wb_chk.sv
module tlb_rd_wb_chk #(
    parameter int PTE_W = 14,
    parameter int PA_W  = 16,
    parameter int VPN_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_ready,
    input logic             rs_valid,
    input logic             rq_valid,
    input logic             rq_ready,
    input logic [VPN_W-1:0] rq_vpn,
    input logic             wb_valid,
    input logic             wb_ready,
    input logic [PA_W-1:0]  wb_addr,
    input logic [PTE_W-1:0] wb_data
);
    // R6: a pending entry write holds its contents
    a_r6_wb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_data) && $stable(wb_addr));

    // R6: an entry write only ends through acceptance
    a_r6_wb_accepted: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wb_valid) |-> $past(wb_ready));

    // R2: every entry write carries the reference bit set
    a_r2_wb_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> wb_data[0]);

    // R2: a refill request holds its page until taken
    a_r2_rq_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rq_valid && !rq_ready |=> rq_valid && $stable(rq_vpn));

    // R4: result, refill and write phases never overlap
    a_r4_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rs_valid, rq_valid, wb_valid}));

    // R1: no lookup accepted while memory traffic is outstanding
    a_r1_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid || wb_valid) |-> !lk_ready);
endmodule

bind tlb_rd_wb tlb_rd_wb_chk #(
    .PTE_W(PPN_W + 2), .PA_W(PA_W), .VPN_W(VPN_W)
) chk_i (
    .clk(clk), .rst_n(rst_n), .lk_ready(lk_ready), .rs_valid(rs_valid),
    .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_vpn(rq_vpn),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data)
);

// File: tb/tlb_rd_wb_tb_top.sv
`timescale 1ns/1ps
module tlb_rd_wb_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_wt = 1'b0;
    logic        lk_valid = 1'b0, lk_write = 1'b0;
    logic [7:0]  lk_vpn = '0;
    logic        lk_ready, rs_valid, rq_valid, wb_valid;
    logic [11:0] rs_ppn;
    logic [7:0]  rq_vpn;
    logic        rq_ready = 1'b0, fr_valid = 1'b0, wb_ready = 1'b0;
    logic [13:0] fr_pte = '0;
    logic [15:0] fr_addr = '0;
    logic [15:0] wb_addr;
    logic [13:0] wb_data;
    logic        pg_valid = 1'b0, pg_all = 1'b0;
    logic [7:0]  pg_vpn = '0;

    always #2 clk = ~clk;

    tlb_rd_wb dut_i (
        .clk(clk), .rst_n(rst_n), .mode_wt(mode_wt),
        .lk_valid(lk_valid), .lk_write(lk_write), .lk_vpn(lk_vpn), .lk_ready(lk_ready),
        .rs_valid(rs_valid), .rs_ppn(rs_ppn),
        .rq_valid(rq_valid), .rq_vpn(rq_vpn), .rq_ready(rq_ready),
        .fr_valid(fr_valid), .fr_pte(fr_pte), .fr_addr(fr_addr),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_addr(wb_addr), .wb_data(wb_data),
        .pg_valid(pg_valid), .pg_all(pg_all), .pg_vpn(pg_vpn)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    logic [1:0] mem_bits [0:255];
    bit         tl_d     [0:255];
    int         res_vpn  [0:7];
    bit         res_v    [0:7];
    int         rr = 0;

    function automatic logic [11:0] ppn_of(int v);
        return 12'(v * 37 + 5);
    endfunction
    function automatic logic [15:0] addr_of(int v);
        return 16'(16'h4000 + v * 4);
    endfunction

    task automatic check(bit ok, string tag, string what, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            summary();
            $finish;
        end
    end

    task automatic purge(int v, bit all);
        @(negedge clk);
        pg_valid = 1'b1; pg_all = all; pg_vpn = 8'(v);
        @(negedge clk);
        pg_valid = 1'b0; pg_all = 1'b0;
        for (int s = 0; s < 8; s++)
            if (all || res_vpn[s] == v) res_v[s] = 1'b0;
        if (!all) mem_bits[v] = 2'b00;
    endtask

    task automatic run(int v, bit wr, bit pf, bit ps, string tag);
        int slot = -1, exp_rq, rq_seen = 0, wb_seen = 0, wbwait = 0;
        bit hit, exp_wb, fill_next = 0, pf_done = 0, got = 0, vpn_bad = 0;
        logic [1:0]  old, nw;
        logic [13:0] exp_data, got_data = '0;
        logic [15:0] got_addr = '0;
        logic [11:0] got_ppn = '0;
        for (int s = 0; s < 8; s++)
            if (res_v[s] && res_vpn[s] == v) slot = s;
        if (ps && slot >= 0) begin res_v[slot] = 1'b0; slot = -1; end
        hit = (slot >= 0);
        old = mem_bits[v];
        nw  = old | 2'b01 | (wr ? 2'b10 : 2'b00);
        if (hit) begin
            exp_rq = 0; exp_wb = wr && !tl_d[v]; exp_data = {ppn_of(v), 2'b11};
        end else begin
            exp_rq = pf ? 2 : 1; exp_wb = mode_wt || (nw != old); exp_data = {ppn_of(v), nw};
        end
        @(negedge clk);
        lk_valid = 1'b1; lk_vpn = 8'(v); lk_write = wr;
        if (ps) begin pg_valid = 1'b1; pg_all = 1'b0; pg_vpn = 8'(v); end
        for (int c = 0; c < 60 && !got; c++) begin
            @(negedge clk);
            lk_valid = 0; pg_valid = 0; rq_ready = 0; wb_ready = 0; fr_valid = 0;
            if (fill_next) begin
                fr_valid = 1'b1; fr_pte = {ppn_of(v), mem_bits[v]}; fr_addr = addr_of(v);
                fill_next = 0;
                if (pf && !pf_done) begin pg_valid = 1'b1; pg_vpn = 8'(v); pf_done = 1; end
            end
            if (rs_valid) begin
                got = 1; got_ppn = rs_ppn;
            end else if (rq_valid) begin
                rq_seen++; rq_ready = 1'b1; fill_next = 1;
                if (rq_vpn != 8'(v)) vpn_bad = 1;
            end else if (wb_valid) begin
                wbwait++;
                if (wbwait == 3) begin
                    wb_ready = 1'b1; wb_seen++;
                    got_data = wb_data; got_addr = wb_addr;
                    mem_bits[v] = wb_data[1:0];
                end
            end
        end
        check(got, tag, "result seen", got, 1);
        check(got_ppn == ppn_of(v), tag, "result page", got_ppn, ppn_of(v));
        check(rq_seen == exp_rq, tag, "refill requests", rq_seen, exp_rq);
        check(!vpn_bad, tag, "refill page", vpn_bad, 0);
        check(wb_seen == int'(exp_wb), tag, "entry writes", wb_seen, exp_wb);
        if (exp_wb && wb_seen == 1) begin
            check(got_data == exp_data, tag, "write data", got_data, exp_data);
            // R13: address comes from the installing refill
            check(got_addr == addr_of(v), tag, "R13 write address", got_addr, addr_of(v));
        end
        if (!hit) begin
            res_vpn[rr] = v; res_v[rr] = 1'b1; rr = (rr + 1) % 8; tl_d[v] = nw[1];
        end else if (wr) begin
            tl_d[v] = 1'b1;
        end
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin mem_bits[i] = 2'(i % 4); tl_d[i] = 0; end
        for (int s = 0; s < 8; s++) begin res_v[s] = 0; res_vpn[s] = -1; end
        repeat (3) @(negedge clk);
        // R1: reset state
        check(lk_ready && !rs_valid && !rq_valid && !wb_valid, "R1", "idle outputs",
              {lk_ready, rs_valid, rq_valid, wb_valid}, 4'b1000);
        rst_n = 1'b1;
        // R2 / R3: every fetched bit pattern under read and write misses
        for (int v = 0; v < 8; v++) run(v, v[2], 0, 0, v[2] ? "R3" : "R2");
        for (int v = 0; v < 8; v++) run(v, 0, 0, 0, "R4");
        for (int v = 0; v < 8; v++) run(v, 1, 0, 0, "R5");
        for (int v = 0; v < 8; v++) run(v, 1, 0, 0, "R5");
        // R12: round-robin eviction
        for (int v = 8; v < 12; v++) run(v, 0, 0, 0, "R12");
        run(4, 0, 0, 0, "R12");
        run(0, 0, 0, 0, "R12");
        run(4, 0, 0, 0, "R12");
        run(6, 0, 0, 0, "R12");
        // R7: single purge
        purge(6, 0);
        run(6, 0, 0, 0, "R7");
        run(7, 0, 0, 0, "R7");
        // R8: full purge
        purge(0, 1);
        run(7, 0, 0, 0, "R8");
        run(8, 1, 0, 0, "R8");
        // R9: purge together with refill data
        run(20, 0, 1, 0, "R9");
        run(20, 0, 0, 0, "R9");
        // R10: purge together with lookup
        run(20, 0, 0, 1, "R10");
        run(20, 0, 0, 0, "R10");
        // R11: forced write on miss
        mode_wt = 1'b1;
        run(31, 0, 0, 0, "R11");
        run(27, 1, 0, 0, "R11");
        run(31, 0, 0, 0, "R11");
        summary();
        $finish;
    end
endmodule